// File: doc/BRIEF.md
# Display Row Sequencer with Bank Switch

This block walks through the rows of a four-row, 80-column display RAM in step with the multiplex timing of a segment display driver. Each multiplex-phase tick selects one row. The block copies that row into an 80-bit display register in a single clock. It also reports which RAM row was taken and which backplane phase it belongs to. A one-cycle strobe marks each new row.

The number of phases in one full sequence depends on the drive mode. In the static and two-phase modes, a bank bit can move the displayed rows to the upper half of the RAM. This lets software build a new frame in rows 2 and 3 while rows 0 and 1 are on screen, and then swap the two. A change of mode or bank is held back until the current sequence has finished, so no frame is ever shown partly in one configuration and partly in another. While the display enable is low, the display register is cleared and the sequence returns to its first phase.

The RAM contents arrive as one flat bus. Row r occupies bits [r*80 +: 80].

Top module: `lcd_row_sequencer`

## Requirements
- R1: With drive_mode = 3 (four phases), successive ticks select rows 0, 1, 2, 3 and then repeat. bp_phase equals the row, and the bank bit has no effect.
- R2: With drive_mode = 2 (three phases), successive ticks select rows 0, 1, 2 and then repeat. bp_phase equals the row, and the bank bit has no effect.
- R3: With drive_mode = 1 (two phases), successive ticks alternate bp_phase between 0 and 1. row_idx is 0 then 1 with bank_sel = 0, and 2 then 3 with bank_sel = 1.
- R4: With drive_mode = 0 (static), every tick gives bp_phase 0. row_idx is 0 with bank_sel = 0 and 2 with bank_sel = 1.
- R5: A tick sampled at a clock edge with disp_en = 1 loads the selected row into seg_out at that edge. The same edge updates row_idx and bp_phase, and raises row_valid for exactly that one cycle.
- R6: Between ticks, seg_out, row_idx and bp_phase hold their values even if the RAM contents change, and row_valid stays low.
- R7: A clock edge with disp_en = 0 clears seg_out, row_valid, row_idx and bp_phase and returns the sequence to its first phase. The first tick after the enable returns is therefore phase 0.
- R8: drive_mode and bank_sel are sampled only on a tick that starts a sequence (phase 0). A change made in the middle of a sequence first shows on the tick that begins the next sequence.
- R9: After reset, seg_out is all zero, row_valid is 0, and row_idx and bp_phase are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_tick | input | 1 | Multiplex-phase advance, one cycle wide |
| drive_mode | input | 2 | 0 static, 1 two-phase, 2 three-phase, 3 four-phase |
| bank_sel | input | 1 | Display the upper rows in static and two-phase modes |
| disp_en | input | 1 | Display enable; 0 blanks the output |
| ram_rows | input | 320 | Display RAM contents, row r at bits [r*80 +: 80] |
| row_idx | output | 2 | RAM row currently latched |
| bp_phase | output | 2 | Backplane phase of the latched row |
| seg_out | output | 80 | Latched segment bits |
| row_valid | output | 1 | One-cycle strobe for a newly latched row |

## Verification
Every result is due one clock after the edge that samples its cause. A tick shows up as new row data and a strobe in the following cycle. A low enable shows up as a blank output in the following cycle. A mid-sequence configuration change shows up only on the next tick that starts a phase-0 step. The bench drives inputs just after a falling edge and lets one rising edge pass. It then compares all outputs at the next falling edge against a bench model advanced by that same edge, so the comparison never depends on process order at the active edge. Directed runs pin down each mode's row order, the bank remap, deferred changes and blanking. Seeded random runs mix ticks, RAM rewrites, configuration changes and enable drops.

// File: rtl/lcdseq_pkg.sv
// Shared types and helpers for the display row sequencer.
// Assumes a RAM of four rows; drive modes are encoded by phase count minus one.
package lcdseq_pkg;

    typedef enum logic [1:0] {
        DRV_STATIC = 2'd0,
        DRV_TWO    = 2'd1,
        DRV_THREE  = 2'd2,
        DRV_FOUR   = 2'd3
    } drv_mode_e;

    // Last phase index of one full sequence for a given drive mode.
    function automatic logic [1:0] last_phase(input drv_mode_e m);
        logic [1:0] r;
        case (m)
            DRV_STATIC: r = 2'd0;
            DRV_TWO:    r = 2'd1;
            DRV_THREE:  r = 2'd2;
            default:    r = 2'd3;
        endcase
        return r;
    endfunction

    // True when the bank bit may move the displayed rows up.
    function automatic logic bank_capable(input drv_mode_e m);
        return (m == DRV_STATIC) || (m == DRV_TWO);
    endfunction

endpackage

// File: rtl/lcdseq_phase_ctr.sv
// Phase counter and configuration holder.
// Keeps the position inside the current multiplex sequence. Captures mode and
// bank only on the tick that begins a sequence, so a change never splits a
// frame. Assumes mux_tick is a single-cycle pulse.
module lcdseq_phase_ctr
    import lcdseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  drv_mode_e  mode_i,
    input  logic       bank_i,
    output logic [1:0] step_phase,
    output drv_mode_e  step_mode,
    output logic       step_bank,
    output drv_mode_e  act_mode,
    output logic       act_bank
);

    logic [1:0] ph_q;
    logic       at_start;

    assign at_start   = (ph_q == 2'd0);
    assign step_phase = ph_q;

    // Purpose: choose the configuration that governs the current step.
    always_comb begin
        step_mode = at_start ? mode_i : act_mode;
        step_bank = at_start ? bank_i : act_bank;
    end

    // Purpose: advance the phase on each enabled tick, wrap at sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= 2'd0;
        end else if (!en) begin
            ph_q <= 2'd0;
        end else if (tick) begin
            if (ph_q == last_phase(step_mode)) begin
                ph_q <= 2'd0;
            end else begin
                ph_q <= ph_q + 2'd1;
            end
        end
    end

    // Purpose: latch mode and bank at the first step of each sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= DRV_STATIC;
            act_bank <= 1'b0;
        end else if (en && tick && at_start) begin
            act_mode <= mode_i;
            act_bank <= bank_i;
        end
    end

endmodule

// File: rtl/lcdseq_row_map.sv
// Maps a sequence phase to a RAM row.
// In the bank-capable modes a set bank bit offsets the row by half the RAM.
// Assumes NROWS is even and the phase never exceeds the mode's last phase.
module lcdseq_row_map
    import lcdseq_pkg::*;
#(
    parameter int NROWS = 4,
    localparam int ROW_W = $clog2(NROWS)
) (
    input  logic [1:0]       phase,
    input  drv_mode_e        mode,
    input  logic             bank,
    output logic [ROW_W-1:0] row
);

    localparam logic [ROW_W-1:0] BANK_OFS = ROW_W'(NROWS / 2);

    // Purpose: add the bank offset where the mode allows it.
    always_comb begin
        row = ROW_W'(phase);
        if (bank && bank_capable(mode)) begin
            row = ROW_W'(phase) + BANK_OFS;
        end
    end

endmodule

// File: rtl/lcdseq_row_mux.sv
// Selects one row out of the flat RAM bus.
// Row r sits at bits [r*NSEG +: NSEG]; the selection is purely combinational.
module lcdseq_row_mux #(
    parameter int NSEG  = 80,
    parameter int NROWS = 4,
    localparam int ROW_W = $clog2(NROWS)
) (
    input  logic [NROWS*NSEG-1:0] ram_flat,
    input  logic [ROW_W-1:0]      sel,
    output logic [NSEG-1:0]       data
);

    logic [NSEG-1:0] rows [NROWS];

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        assign rows[r] = ram_flat[r*NSEG +: NSEG];
    end

    // Purpose: pick the addressed row.
    always_comb begin
        data = rows[sel];
    end

endmodule

// File: rtl/lcdseq_out_reg.sv
// Display register with a row strobe.
// Loads row data, row index and phase on an enabled tick, holds between ticks,
// and clears everything while the display is disabled.
module lcdseq_out_reg #(
    parameter int NSEG  = 80,
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [NSEG-1:0]  row_data,
    input  logic [ROW_W-1:0] row_sel,
    input  logic [1:0]       phase,
    output logic [NSEG-1:0]  seg_q,
    output logic [ROW_W-1:0] row_q,
    output logic [1:0]       phase_q,
    output logic             valid_q
);

    // Purpose: latch the selected row or blank the display.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            seg_q   <= '0;
            row_q   <= '0;
            phase_q <= '0;
            valid_q <= 1'b0;
        end else if (tick) begin
            seg_q   <= row_data;
            row_q   <= row_sel;
            phase_q <= phase;
            valid_q <= 1'b1;
        end else begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lcd_row_sequencer.sv
// Display row sequencer top.
// Steps through the display RAM rows on each multiplex tick. The order depends
// on the drive mode, with an optional bank remap in the static and two-phase
// modes. Presents each row through a registered 80-bit display latch.
// Assumes a four-row RAM supplied as a flat bus and a single-cycle tick.
module lcd_row_sequencer
    import lcdseq_pkg::*;
#(
    parameter int NSEG  = 80,
    parameter int NROWS = 4,
    localparam int ROW_W = $clog2(NROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mux_tick,
    input  logic [1:0]            drive_mode,
    input  logic                  bank_sel,
    input  logic                  disp_en,
    input  logic [NROWS*NSEG-1:0] ram_rows,
    output logic [ROW_W-1:0]      row_idx,
    output logic [1:0]            bp_phase,
    output logic [NSEG-1:0]       seg_out,
    output logic                  row_valid
);

    logic [1:0]       step_phase;
    drv_mode_e        step_mode;
    logic             step_bank;
    drv_mode_e        act_mode;
    logic             act_bank;
    logic [ROW_W-1:0] sel_row;
    logic [NSEG-1:0]  sel_data;

    lcdseq_phase_ctr u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (mux_tick),
        .en         (disp_en),
        .mode_i     (drv_mode_e'(drive_mode)),
        .bank_i     (bank_sel),
        .step_phase (step_phase),
        .step_mode  (step_mode),
        .step_bank  (step_bank),
        .act_mode   (act_mode),
        .act_bank   (act_bank)
    );

    lcdseq_row_map #(.NROWS(NROWS)) u_map (
        .phase (step_phase),
        .mode  (step_mode),
        .bank  (step_bank),
        .row   (sel_row)
    );

    lcdseq_row_mux #(.NSEG(NSEG), .NROWS(NROWS)) u_mux (
        .ram_flat (ram_rows),
        .sel      (sel_row),
        .data     (sel_data)
    );

    lcdseq_out_reg #(.NSEG(NSEG), .ROW_W(ROW_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (mux_tick),
        .en       (disp_en),
        .row_data (sel_data),
        .row_sel  (sel_row),
        .phase    (step_phase),
        .seg_q    (seg_out),
        .row_q    (row_idx),
        .phase_q  (bp_phase),
        .valid_q  (row_valid)
    );

endmodule

// File: rtl/lcd_row_sequencer_chk.sv
// Property checker for the display row sequencer, bound to the top module.
module lcd_row_sequencer_chk
    import lcdseq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mux_tick,
    input logic        disp_en,
    input logic [1:0]  row_idx,
    input logic [1:0]  bp_phase,
    input logic [79:0] seg_out,
    input logic        row_valid,
    input logic [1:0]  ph_q,
    input drv_mode_e   act_mode,
    input logic        act_bank
);

    // R1 R2: a latched phase never exceeds the active mode's last phase
    a_r1_phase_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> (bp_phase <= last_phase(act_mode)));

    // R4: static mode always shows phase 0
    a_r4_static_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && act_mode == DRV_STATIC) |-> (bp_phase == 2'd0));

    // R3: bank selects the half of the RAM in bank-capable modes
    a_r3_bank_half: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && bank_capable(act_mode)) |-> (row_idx[1] == act_bank));

    // R5: a strobe only follows an enabled tick
    a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> ($past(mux_tick) && $past(disp_en)));

    // R6: outputs hold between ticks
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !mux_tick) |=> ($stable(seg_out) && $stable(row_idx)
                                    && $stable(bp_phase) && !row_valid));

    // R7: disabled display is blanked on the next cycle
    a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> (seg_out == '0 && !row_valid && bp_phase == 2'd0));

    // R8: configuration frozen inside a sequence
    a_r8_no_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != 2'd0) |=> ($stable(act_mode) && $stable(act_bank)));

endmodule

bind lcd_row_sequencer lcd_row_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mux_tick  (mux_tick),
    .disp_en   (disp_en),
    .row_idx   (row_idx),
    .bp_phase  (bp_phase),
    .seg_out   (seg_out),
    .row_valid (row_valid),
    .ph_q      (step_phase),
    .act_mode  (act_mode),
    .act_bank  (act_bank)
);

// File: tb/lcd_row_sequencer_tb.sv
`timescale 1ns/1ps
module lcd_row_sequencer_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mux_tick = 1'b0;
    logic [1:0]   drive_mode = 2'd0;
    logic         bank_sel = 1'b0;
    logic         disp_en = 1'b0;
    logic [319:0] ram_rows = '0;
    logic [1:0]   row_idx;
    logic [1:0]   bp_phase;
    logic [79:0]  seg_out;
    logic         row_valid;

    int total = 0;
    int bad   = 0;

    // bench model state
    logic [1:0]  m_ph = 0;
    logic [1:0]  m_mode = 0;
    logic        m_bank = 0;
    logic [1:0]  e_row = 0;
    logic [1:0]  e_ph = 0;
    logic [79:0] e_seg = '0;
    logic        e_val = 0;

    always #2.5 clk = ~clk;

    lcd_row_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .mux_tick(mux_tick), .drive_mode(drive_mode),
        .bank_sel(bank_sel), .disp_en(disp_en), .ram_rows(ram_rows),
        .row_idx(row_idx), .bp_phase(bp_phase), .seg_out(seg_out), .row_valid(row_valid)
    );

    function automatic logic [1:0] map_row(input logic [1:0] ph, input logic [1:0] md, input logic bk);
        return (bk && md <= 2'd1) ? ph + 2'd2 : ph;
    endfunction

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'd0: return "R4";
            2'd1: return "R3";
            2'd2: return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model update for one rising edge
    task automatic model_edge();
        if (!disp_en) begin
            m_ph = 0; e_seg = '0; e_val = 0; e_row = 0; e_ph = 0;
        end else if (mux_tick) begin
            if (m_ph == 0) begin m_mode = drive_mode; m_bank = bank_sel; end
            e_row = map_row(m_ph, m_mode, m_bank);
            e_ph  = m_ph;
            e_seg = ram_rows[e_row*80 +: 80];
            e_val = 1;
            m_ph  = (m_ph == m_mode) ? 2'd0 : m_ph + 2'd1;
        end else begin
            e_val = 0;
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " row_idx"},   80'(row_idx),   80'(e_row));
        chk({tag, " bp_phase"},  80'(bp_phase),  80'(e_ph));
        chk({"R5 seg_out ", tag}, seg_out,       e_seg);
        chk({"R5 row_valid ", tag}, 80'(row_valid), 80'(e_val));
    endtask

    task automatic step(input logic t, input logic [1:0] md, input logic bk, input logic en, input string tag);
        mux_tick = t; drive_mode = md; bank_sel = bk; disp_en = en;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    // directed tick with a hard-coded expected row and phase
    task automatic tick_expect(input string tag, input logic [1:0] md, input logic bk,
                               input logic [1:0] xr, input logic [1:0] xp);
        step(1'b1, md, bk, 1'b1, tag);
        chk({tag, " directed row"},   80'(row_idx),  80'(xr));
        chk({tag, " directed phase"}, 80'(bp_phase), 80'(xp));
        step(1'b0, md, bk, 1'b1, tag);
    endtask

    task automatic fill_ram();
        for (int i = 0; i < 10; i++) ram_rows[i*32 +: 32] = $urandom;
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4242);
        fill_ram();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 seg_out",   seg_out, '0);
        chk("R9 row_valid", 80'(row_valid), 80'(0));
        chk("R9 row_idx",   80'(row_idx), 80'(0));
        chk("R9 bp_phase",  80'(bp_phase), 80'(0));

        step(1'b0, 2'd0, 1'b0, 1'b1, "R7");
        // R4 static, both banks
        tick_expect("R4", 2'd0, 1'b0, 2'd0, 2'd0);
        tick_expect("R4", 2'd0, 1'b0, 2'd0, 2'd0);
        tick_expect("R4", 2'd0, 1'b1, 2'd2, 2'd0);
        tick_expect("R4", 2'd0, 1'b1, 2'd2, 2'd0);
        // R3 two-phase
        tick_expect("R3", 2'd1, 1'b0, 2'd0, 2'd0);
        tick_expect("R3", 2'd1, 1'b0, 2'd1, 2'd1);
        tick_expect("R3", 2'd1, 1'b0, 2'd0, 2'd0);
        tick_expect("R3", 2'd1, 1'b0, 2'd1, 2'd1);
        tick_expect("R3", 2'd1, 1'b1, 2'd2, 2'd0);
        tick_expect("R3", 2'd1, 1'b1, 2'd3, 2'd1);
        // R2 three-phase, bank ignored
        for (int k = 0; k < 6; k++)
            tick_expect("R2", 2'd2, 1'b1, 2'(k % 3), 2'(k % 3));
        // R1 four-phase, bank ignored
        for (int k = 0; k < 8; k++)
            tick_expect("R1", 2'd3, k[0], 2'(k % 4), 2'(k % 4));
        // R8 change mid-sequence: two steps of four-phase, then ask for static bank 1
        tick_expect("R8", 2'd3, 1'b0, 2'd0, 2'd0);
        tick_expect("R8", 2'd3, 1'b0, 2'd1, 2'd1);
        tick_expect("R8", 2'd0, 1'b1, 2'd2, 2'd2);
        tick_expect("R8", 2'd0, 1'b1, 2'd3, 2'd3);
        tick_expect("R8", 2'd0, 1'b1, 2'd2, 2'd0);
        // R6 hold while RAM changes
        tick_expect("R6", 2'd2, 1'b0, 2'd0, 2'd0);
        fill_ram();
        step(1'b0, 2'd2, 1'b0, 1'b1, "R6");
        step(1'b0, 2'd2, 1'b0, 1'b1, "R6");
        // R7 blank mid-sequence, restart at phase 0
        step(1'b0, 2'd2, 1'b0, 1'b0, "R7");
        chk("R7 blank seg", seg_out, '0);
        tick_expect("R7", 2'd2, 1'b0, 2'd0, 2'd0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic t, en, bk;
            logic [1:0] md;
            t  = ($urandom % 3) == 0;
            en = ($urandom % 40) != 0;
            md = ($urandom % 8 == 0) ? 2'($urandom) : drive_mode;
            bk = ($urandom % 8 == 0) ? 1'($urandom) : bank_sel;
            if ($urandom % 5 == 0) fill_ram();
            step(t, md, bk, en, mode_tag(m_mode));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule